// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

The block turns a gated serial bitstream into HDLC frames. Bits arrive least significant first, one per cycle on which `bit_valid` is high. Cycles with `bit_valid` low are skipped. The block does the following:

- finds the 0x7E flag;
- removes the zero inserted after five ones;
- detects the abort pattern;
- checks the 16-bit frame check sequence with the reflected CCITT polynomial (x^16+x^12+x^5+1, preset 0xFFFF, good residue 0xF0B8).

Recovered bytes, including the two check bytes, go out on a one-byte-wide write port to a receive FIFO. Each write carries a status tag. The block also pulses an event when the link comes up, when a frame closes and when an abort is seen.

An optional address filter compares the first byte, or the first two bytes, of each frame against a primary and a secondary value. Frames that fail the comparison are not written. Link-activation and abort marker bytes are written whether or not a frame matched.

Byte output runs one byte behind reception. This delay lets the end-of-frame status sit on the last byte, and it lets a two-byte address test decide before the first byte leaves.

The controller has three states, `ST_HUNT`, `ST_IDLE` and `ST_RECV`:

| From | Event | To | Writes and pulses |
|---|---|---|---|
| `ST_HUNT` | flag | `ST_IDLE` | link-up marker byte, `ev_open` |
| `ST_IDLE` | completed byte | `ST_RECV` | none |
| `ST_IDLE` | flag | `ST_IDLE` | none (idle flag) |
| `ST_RECV` | completed byte | `ST_RECV` | none |
| `ST_RECV` | flag | `ST_IDLE` | end-of-frame write, `ev_close` |
| `ST_IDLE` or `ST_RECV` | seventh consecutive one | `ST_HUNT` | abort marker byte, `ev_abort` |
| any state | `terminate` high or `enable` low | `ST_HUNT` | none |

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `link_up` is 0 and no write occurs until a flag is received.
- R2: In the hunt state, a received flag (bits 0,1,1,1,1,1,1,0) causes one write with tag 4 and data 0x7E. It also pulses `ev_open` and raises `link_up`.
- R3: Inside a frame, a zero that follows five consecutive ones is discarded. Bytes are assembled least significant bit first and written in order with tag 0. Tags take only the values 0 to 5.
- R4: The two check bytes are written after the data, low byte first. The last byte of a closed frame carries tag 1 if the check residue is 0xF0B8, and tag 2 otherwise.
- R5: If a frame ends with a number of bits that is not a multiple of eight, the leftover bits are dropped and the last whole byte carries tag 3.
- R6: Seven consecutive ones while the link is up cause one write with tag 5 and data 0x7F, pulse `ev_abort` and drop `link_up`. No end-of-frame tag follows.
- R7: A run of ones continuing past 15 keeps the link down with no writes, and the next flag brings the link up again as in R2.
- R8: With `addr_en`=1 and `addr_two`=0, a frame is written only if its first byte equals `addr_pri`.
- R9: With `addr_en`=1 and `addr_two`=1, a frame is written only if its first byte equals `addr_pri` and its second byte equals `addr_sec`.
- R10: `terminate` high, or `enable` low, drops the link on the next cycle and discards the frame in progress without any write. The next flag then produces the link-up marker of R2.
- R11: `ev_close` pulses once for every frame closed by a flag, regardless of the check result, the byte alignment or the filter. One flag may close a frame and open the next.
- R12: Cycles with `bit_valid` low produce no write and no event, and do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable; low holds the hunt state |
| terminate | input | 1 | Forces an immediate return to flag hunt |
| bit_valid | input | 1 | Qualifies `bit_in` on this cycle |
| bit_in | input | 1 | Serial data bit |
| addr_en | input | 1 | Enables the address filter |
| addr_two | input | 1 | 1: compare two bytes; 0: compare the first byte only |
| addr_pri | input | 8 | Primary address value |
| addr_sec | input | 8 | Secondary address value |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Byte to write |
| wr_tag | output | 3 | Status tag: 0 data, 1 good end, 2 bad-check end, 3 non-integer end, 4 link-up marker, 5 abort marker |
| ev_open | output | 1 | Link activated by a flag |
| ev_close | output | 1 | Frame closed by a flag |
| ev_abort | output | 1 | Abort received |
| link_up | output | 1 | Link active |

## Verification
On every cycle, the assertions check three things:

- that killing the receiver empties the output on the next cycle;
- that idle bit slots produce nothing;
- that each event pulse agrees with `link_up` and with the marker byte written beside it.

Properties cannot show whether bytes are correctly destuffed, whether the check residue is right, or whether the address filter decides correctly. The vector table and the directed scenarios compare those against reference values. The directed scenarios also cover shared flags, non-integer endings, aborts followed by long runs of ones, and restarts after terminate or enable toggling.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'h7F;

    typedef enum logic [2:0] {
        TAG_DATA     = 3'd0,
        TAG_END_OK   = 3'd1,
        TAG_END_BAD  = 3'd2,
        TAG_END_PART = 3'd3,
        TAG_LINK_UP  = 3'd4,
        TAG_ABORT    = 3'd5
    } rx_tag_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_IDLE = 2'd1,
        ST_RECV = 2'd2
    } rx_state_e;
endpackage

// File: rtl/hdlc_rx_bitfront.sv
module hdlc_rx_bitfront
    import hdlc_rx_pkg::*;
#(
    parameter int RUN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              is_flag,
    output logic              is_abort,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              partial
);
    localparam int HIST_W = 2 * BYTE_W;
    localparam int LAG    = BYTE_W - 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0]  ones;
    logic [HIST_W-1:0] hist;
    logic [2:0]        fill;
    logic [2:0]        ph;
    logic              is_stuff;
    logic              data_bit;

    assign is_flag   = bit_valid && !bit_in && (ones == RUN_W'(6));
    assign is_stuff  = bit_valid && !bit_in && (ones == RUN_W'(5));
    assign is_abort  = bit_valid &&  bit_in && (ones == RUN_W'(6));
    assign data_bit  = bit_valid && !is_flag && !is_stuff;
    assign byte_done = data_bit && (fill == 3'(LAG)) && (ph == 3'(LAG));
    assign byte_val  = hist[BYTE_W+1:2];
    assign partial   = (ph != 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ones <= '0;
            fill <= '0;
            ph   <= '0;
            if (!rst_n) hist <= '0;
        end else if (bit_valid) begin
            if (bit_in) ones <= (ones == RUN_MAX) ? ones : ones + 1'b1;
            else        ones <= '0;
            if (is_flag || is_abort) begin
                fill <= '0;
                ph   <= '0;
            end else if (data_bit) begin
                hist <= {bit_in, hist[HIST_W-1:1]};
                if (fill != 3'(LAG)) fill <= fill + 1'b1;
                else                 ph   <= ph + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
#(
    parameter int           CRC_W = 16,
    parameter logic [15:0]  POLY  = 16'h8408,
    parameter logic [15:0]  INIT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] stage [0:BYTE_W];

    assign stage[0] = crc ^ {{(CRC_W-BYTE_W){1'b0}}, din};

    for (genvar i = 0; i < BYTE_W; i++) begin : g_step
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY[CRC_W-1:0])
                                        :  (stage[i] >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= INIT[CRC_W-1:0];
        else if (upd)       crc <= stage[BYTE_W];
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int          RUN_W   = 5,
    parameter int          CRC_W   = 16,
    parameter logic [15:0] RESIDUE = 16'hF0B8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              terminate,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              addr_en,
    input  logic              addr_two,
    input  logic [BYTE_W-1:0] addr_pri,
    input  logic [BYTE_W-1:0] addr_sec,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [2:0]        wr_tag,
    output logic              ev_open,
    output logic              ev_close,
    output logic              ev_abort,
    output logic              link_up
);
    rx_state_e         st, st_n;
    logic [1:0]        bc, bc_n;
    logic              pass_r, pass_n, pv, pv_n;
    logic [BYTE_W-1:0] pd, pd_n;
    logic              kill, crc_init, crc_upd;
    logic              is_flag, is_abort, byte_done, partial;
    logic [BYTE_W-1:0] byte_val;
    logic [CRC_W-1:0]  crc;
    logic              pass_now, end_pass;
    logic              o_wr, o_open, o_close, o_abort;
    logic [BYTE_W-1:0] o_data;
    rx_tag_e           o_tag;

    assign kill = !enable || terminate;

    hdlc_rx_bitfront #(.RUN_W(RUN_W)) u_front (
        .clk(clk), .rst_n(rst_n), .clr(kill), .bit_valid(bit_valid), .bit_in(bit_in),
        .is_flag(is_flag), .is_abort(is_abort), .byte_done(byte_done),
        .byte_val(byte_val), .partial(partial)
    );

    hdlc_rx_crc #(.CRC_W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
        .din(byte_val), .crc(crc)
    );

    assign pass_now = (addr_en && addr_two && bc == 2'd1) ? (pass_r && byte_val == addr_sec)
                                                          : pass_r;
    assign end_pass = pass_r && !(addr_en && addr_two && bc == 2'd1);

    always_comb begin
        st_n = st; bc_n = bc; pass_n = pass_r; pv_n = pv; pd_n = pd;
        o_wr = 1'b0; o_data = '0; o_tag = TAG_DATA;
        o_open = 1'b0; o_close = 1'b0; o_abort = 1'b0;
        crc_init = 1'b0; crc_upd = 1'b0;
        if (kill) begin
            st_n = ST_HUNT; bc_n = '0; pv_n = 1'b0; crc_init = 1'b1;
        end else begin
            unique case (st)
                ST_HUNT: begin
                    if (is_flag) begin
                        st_n = ST_IDLE; o_wr = 1'b1; o_data = FLAG_BYTE;
                        o_tag = TAG_LINK_UP; o_open = 1'b1;
                        bc_n = '0; pv_n = 1'b0; crc_init = 1'b1;
                    end
                end
                ST_IDLE, ST_RECV: begin
                    if (is_abort) begin
                        st_n = ST_HUNT; o_wr = 1'b1; o_data = ABORT_BYTE;
                        o_tag = TAG_ABORT; o_abort = 1'b1;
                        bc_n = '0; pv_n = 1'b0;
                    end else if (is_flag) begin
                        if (st == ST_RECV) begin
                            o_close = 1'b1;
                            if (pv && end_pass) begin
                                o_wr = 1'b1; o_data = pd;
                                if (partial)              o_tag = TAG_END_PART;
                                else if (crc == RESIDUE)  o_tag = TAG_END_OK;
                                else                      o_tag = TAG_END_BAD;
                            end
                        end
                        st_n = ST_IDLE; bc_n = '0; pv_n = 1'b0; crc_init = 1'b1;
                    end else if (byte_done) begin
                        st_n = ST_RECV; crc_upd = 1'b1;
                        if (pv && pass_now) begin
                            o_wr = 1'b1; o_data = pd; o_tag = TAG_DATA;
                        end
                        pd_n = byte_val; pv_n = 1'b1;
                        if (bc != 2'd2) bc_n = bc + 1'b1;
                        if (bc == 2'd0)      pass_n = !addr_en || (byte_val == addr_pri);
                        else if (bc == 2'd1) pass_n = pass_now;
                    end
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_HUNT; bc <= '0; pass_r <= 1'b0; pv <= 1'b0; pd <= '0;
        end else begin
            st <= st_n; bc <= bc_n; pass_r <= pass_n; pv <= pv_n; pd <= pd_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en <= 1'b0; wr_data <= '0; wr_tag <= '0;
            ev_open <= 1'b0; ev_close <= 1'b0; ev_abort <= 1'b0;
        end else begin
            wr_en <= o_wr; wr_data <= o_data; wr_tag <= o_tag;
            ev_open <= o_open; ev_close <= o_close; ev_abort <= o_abort;
        end
    end

    assign link_up = (st != ST_HUNT);
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       terminate,
    input logic       bit_valid,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [2:0] wr_tag,
    input logic       ev_open,
    input logic       ev_close,
    input logic       ev_abort,
    input logic       link_up
);
    assert_kill_drops_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || terminate) |=> (!link_up && !wr_en));

    assert_idle_slot_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> (!wr_en && !ev_open && !ev_close && !ev_abort));

    assert_open_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_open |-> (link_up && wr_en && wr_tag == 3'd4 && wr_data == 8'h7E));

    assert_abort_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |-> (!link_up && wr_en && wr_tag == 3'd5 && wr_data == 8'h7F));

    assert_events_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_open, ev_close, ev_abort}));

    assert_close_keeps_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_close |-> link_up);

    assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_tag <= 3'd5));

    assert_down_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !link_up) |-> (wr_tag == 3'd5));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .terminate(terminate),
    .bit_valid(bit_valid), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .ev_open(ev_open), .ev_close(ev_close), .ev_abort(ev_abort), .link_up(link_up)
);

// File: tb/hdlc_rx_deframer_bench.sv
module hdlc_rx_deframer_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, enable, terminate, bit_valid, bit_in, addr_en, addr_two;
    logic [7:0] addr_pri, addr_sec, wr_data;
    logic [2:0] wr_tag;
    logic       wr_en, ev_open, ev_close, ev_abort, link_up;

    hdlc_rx_deframer u_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .terminate(terminate),
        .bit_valid(bit_valid), .bit_in(bit_in), .addr_en(addr_en), .addr_two(addr_two),
        .addr_pri(addr_pri), .addr_sec(addr_sec), .wr_en(wr_en), .wr_data(wr_data),
        .wr_tag(wr_tag), .ev_open(ev_open), .ev_close(ev_close), .ev_abort(ev_abort),
        .link_up(link_up)
    );

    // vector: {aen, two, bad, n[2:0], pri, sec, b3, b2, b1, b0}
    localparam int NV = 8;
    localparam logic [53:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 32'h00030201},
        {1'b0, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 32'h3F7EFFFF},
        {1'b0, 1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 32'h0000AA55},
        {1'b1, 1'b0, 1'b0, 3'd2, 8'h10, 8'h00, 32'h00005A10},
        {1'b1, 1'b0, 1'b0, 3'd2, 8'h10, 8'h00, 32'h00005A11},
        {1'b1, 1'b1, 1'b0, 3'd3, 8'h10, 8'h20, 32'h00332010},
        {1'b1, 1'b1, 1'b0, 3'd3, 8'h10, 8'h20, 32'h00332110},
        {1'b1, 1'b0, 1'b0, 3'd2, 8'h7E, 8'h00, 32'h0000007E}
    };

    int n_chk = 0, n_err = 0;
    int cap_n = 0, n_open = 0, n_close = 0, n_abort = 0;
    logic [7:0] cap_d [0:63];
    logic [2:0] cap_t [0:63];
    logic [7:0] fb [0:7];
    logic [15:0] last_fcs;
    int tx_ones = 0;
    bit gap_mode = 1'b0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (wr_en && cap_n < 64) begin
            cap_d[cap_n] = wr_data;
            cap_t[cap_n] = wr_tag;
            cap_n++;
        end
        if (ev_open)  n_open++;
        if (ev_close) n_close++;
        if (ev_abort) n_abort++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr_cap();
        @(posedge clk);
        cap_n = 0; n_open = 0; n_close = 0; n_abort = 0;
    endtask

    task automatic quiet(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        if (gap_mode) begin
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic send_frame(input int n, input bit bad);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            c = crc_step(c, fb[k]);
            send_byte(fb[k]);
        end
        c = ~c;
        if (bad) c[0] = ~c[0];
        last_fcs = c;
        send_byte(c[7:0]);
        send_byte(c[15:8]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [53:0] e;
        int n, exp_n, bad_bytes;
        bit pass;
        string req;
        rst_n = 1'b0; enable = 1'b1; terminate = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        addr_en = 1'b0; addr_two = 1'b0; addr_pri = 8'h00; addr_sec = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        quiet(3);

        // R1: reset state
        chk(link_up == 1'b0, "R1 link_up", link_up, 0);
        chk(cap_n == 0 && wr_en == 1'b0, "R1 writes", cap_n, 0);

        // R2: link activation
        clr_cap();
        send_flag();
        quiet(3);
        chk(cap_n == 1 && cap_t[0] == 3'd4 && cap_d[0] == 8'h7E, "R2 marker", {cap_t[0], cap_d[0]}, 12'h47E);
        chk(n_open == 1 && link_up == 1'b1, "R2 open", n_open, 1);

        // Vector table: R3, R4, R8, R9, R11
        for (int v = 0; v < NV; v++) begin
            e = VEC[v];
            addr_en = e[53]; addr_two = e[52]; addr_pri = e[47:40]; addr_sec = e[39:32];
            n = int'(e[50:48]);
            for (int k = 0; k < 4; k++) fb[k] = e[8*k +: 8];
            clr_cap();
            send_frame(n, e[51]);
            send_flag();
            quiet(4);
            pass  = !e[53] || (fb[0] == e[47:40] && (!e[52] || fb[1] == e[39:32]));
            exp_n = pass ? n + 2 : 0;
            req   = !e[53] ? "R3" : (e[52] ? "R9" : "R8");
            chk(cap_n == exp_n, {req, " write count"}, cap_n, exp_n);
            if (pass && cap_n == exp_n) begin
                bad_bytes = 0;
                for (int k = 0; k < n; k++)
                    if (cap_d[k] != fb[k] || cap_t[k] != 3'd0) bad_bytes++;
                if (cap_d[n] != last_fcs[7:0] || cap_d[n+1] != last_fcs[15:8]) bad_bytes++;
                chk(bad_bytes == 0, "R3 data bytes", bad_bytes, 0);
                chk(cap_t[n+1] == (e[51] ? 3'd2 : 3'd1), "R4 end tag", cap_t[n+1], e[51] ? 2 : 1);
            end
            chk(n_close == 1, "R11 close per frame", n_close, 1);
        end
        addr_en = 1'b0; addr_two = 1'b0;

        // R11: shared flag between back-to-back frames
        clr_cap();
        fb[0] = 8'hA1; fb[1] = 8'hB2;
        send_frame(2, 1'b0);
        send_flag();
        fb[0] = 8'hC3;
        send_frame(1, 1'b0);
        send_flag();
        quiet(4);
        chk(n_close == 2, "R11 shared flag closes", n_close, 2);
        chk(cap_n == 7 && cap_t[3] == 3'd1 && cap_t[6] == 3'd1 && cap_d[4] == 8'hC3,
            "R11 shared flag bytes", cap_n, 7);

        // R12: gapped bit_valid
        gap_mode = 1'b1;
        clr_cap();
        fb[0] = 8'h3C; fb[1] = 8'hFE; fb[2] = 8'h81;
        send_frame(3, 1'b0);
        send_flag();
        gap_mode = 1'b0;
        quiet(4);
        chk(cap_n == 5 && cap_d[1] == 8'hFE && cap_t[4] == 3'd1, "R12 gapped frame", cap_n, 5);

        // R5: non-integer ending
        clr_cap();
        fb[0] = 8'h5C;
        send_frame(1, 1'b0);
        repeat (3) send_data_bit(1'b0);
        send_flag();
        quiet(4);
        chk(cap_n == 3 && cap_t[2] == 3'd3, "R5 partial tag", cap_t[2], 3);
        chk(n_close == 1, "R11 partial still closes", n_close, 1);

        // R6: abort mid-frame
        clr_cap();
        send_byte(8'h12);
        send_byte(8'h34);
        repeat (7) send_raw(1'b1);
        quiet(4);
        chk(cap_n == 1 && cap_t[0] == 3'd5 && cap_d[0] == 8'h7F, "R6 abort marker", cap_n, 1);
        chk(n_abort == 1 && n_close == 0 && link_up == 1'b0, "R6 link down", link_up, 0);

        // R7: long run of ones keeps link down
        repeat (20) send_raw(1'b1);
        quiet(4);
        chk(cap_n == 1 && link_up == 1'b0, "R7 run stays down", cap_n, 1);
        send_flag();
        quiet(3);
        chk(cap_n == 2 && cap_t[1] == 3'd4 && link_up == 1'b1, "R7 relink", cap_t[1], 4);

        // R10: terminate
        clr_cap();
        send_byte(8'h12);
        send_byte(8'h34);
        @(negedge clk);
        bit_valid = 1'b0; terminate = 1'b1;
        @(negedge clk);
        terminate = 1'b0;
        quiet(3);
        chk(link_up == 1'b0 && cap_n == 0, "R10 terminate", cap_n, 0);
        send_flag();
        quiet(3);
        chk(cap_n == 1 && cap_t[0] == 3'd4 && n_open == 1, "R10 rehunt after terminate", cap_t[0], 4);

        // R10: enable toggle
        clr_cap();
        send_byte(8'h99);
        @(negedge clk);
        bit_valid = 1'b0; enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        quiet(3);
        chk(link_up == 1'b0 && cap_n == 0, "R10 enable toggle", cap_n, 0);
        send_flag();
        quiet(3);
        chk(cap_n == 1 && cap_t[0] == 3'd4 && link_up == 1'b1, "R10 rehunt after toggle", cap_t[0], 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule